// File: doc/BRIEF.md
# Capture / Auto-Reload Timer with Square-Wave Output

This block is a 16-bit timer/counter built from two 8-bit halves, where the high half advances on the carry or borrow of the low half. It counts either system-clock ticks divided by a fixed prescale or falling edges seen on an external count pin. A byte-wide register port loads the control word, the flags, the count and a 16-bit reload/capture register, and reads them back.

There are three modes of operation. In capture mode the counter runs freely and an external strobe latches the count. In auto-reload mode an overflow reloads the count. With up/down enabled, the strobe pin sets the direction, and an underflow reloads all-ones. In square-wave mode the counter runs at half the system clock, and each overflow reloads it and toggles an output pin. An overflow flag and an external-event flag are both combined into one interrupt request.

Top module: `cap_timer16`

## Requirements
- R1: After a synchronous reset, every register reads 0. The `ovf_flag`, `ext_flag`, `irq` and `clk_out` outputs are 0.
- R2: When run=1, source-select=0 and square-wave mode is off, the count advances by one every 12 system clocks.
- R3: When source-select=1, the count advances once for each falling edge on `cnt_pin`, taken after a two-flop synchroniser. A falling edge means one sample high followed by one sample low. With run=0 the count holds.
- R4: In capture mode, when ext-enable=1, a falling edge on `strobe_pin` copies the count into the reload/capture register and sets the external flag. An up-count from FFFFh wraps to 0000h and sets the overflow flag.
- R5: In reload mode with up/down off, an up-count from FFFFh loads the reload register and sets the overflow flag. When ext-enable=1, a falling edge on `strobe_pin` also loads the reload register and sets the external flag.
- R6: In reload mode with up/down on, the synchronised `strobe_pin` level sets the direction (1 counts up, 0 counts down). A down-count while the count equals the reload register loads FFFFh. The overflow flag is set and the external flag toggles on every overflow and every underflow. Strobe edges do not set the external flag.
- R7: In square-wave mode the count advances every 2 clocks, and an overflow reloads it. When out-enable=1, `clk_out` toggles on each overflow. With out-enable=0, `clk_out` holds. Overflows in this mode leave the overflow flag unchanged.
- R8: `irq` is the OR of the overflow flag and the external flag, and changes on the same clock edge as they do.
- R9: A register write to the flags wins over a hardware set of a flag in the same cycle. A write to a count byte wins over counting in the same cycle.
- R10: Register map, byte wide, with `rd_data` valid one clock after `rd_addr`:
  - 0 is control: bit0 run, bit1 source-select, bit2 capture mode, bit3 ext-enable, bit4 up/down, bit5 square-wave mode, bit6 out-enable; bit7 reads 0.
  - 1 is flags: bit0 overflow, bit1 external.
  - 2 and 3 are the count low and high bytes.
  - 4 and 5 are the reload/capture low and high bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Registered read data |
| cnt_pin | input | 1 | External count input |
| strobe_pin | input | 1 | External capture/reload strobe and direction input |
| ovf_flag | output | 1 | Overflow/underflow flag |
| ext_flag | output | 1 | External-event flag |
| irq | output | 1 | Interrupt request |
| clk_out | output | 1 | Square-wave output |

## Verification
The hardest case to reach is a register write and a hardware event landing on the same clock edge. A pin edge reaches the counter only after the synchroniser and the edge detector. The bench therefore drops `cnt_pin` low and waits two clock edges, then issues the write so that it is sampled at the very edge where the pin event takes effect. The same timing is used for both the flag-priority and the count-priority checks. The underflow is reached by preloading the count just above the reload value with the strobe pin held low, then stepping it one pin edge at a time.

// File: rtl/cap_timer16_pkg.sv
package cap_timer16_pkg;
  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_FLAG = 3'd1;
  localparam logic [2:0] RA_CNTL = 3'd2;
  localparam logic [2:0] RA_CNTH = 3'd3;
  localparam logic [2:0] RA_RLDL = 3'd4;
  localparam logic [2:0] RA_RLDH = 3'd5;

  // control word, bit0 = run ... bit6 = out_en
  typedef struct packed {
    logic out_en;
    logic sqw_mode;
    logic updn_en;
    logic ext_en;
    logic cap_mode;
    logic src_ext;
    logic run;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] fall_o
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [STAGES-1:0] sh;
    logic              prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        sh   <= '0;
        prev <= 1'b0;
      end else begin
        sh   <= {sh[STAGES-2:0], pin_i[i]};
        prev <= sh[STAGES-1];
      end
    end
    assign level_o[i] = sh[STAGES-1];
    assign fall_o[i]  = prev & ~sh[STAGES-1];

    // R3
    single_fall_chk: assert property (@(posedge clk) disable iff (rst)
      fall_o[i] |=> !fall_o[i]);
  end
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic fast_i,
  output logic tick_o
);
  localparam int PW = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1;

  logic [PW-1:0] pc;
  logic [PW-1:0] lim;

  assign lim    = fast_i ? PW'(DIV_FAST - 1) : PW'(DIV_SLOW - 1);
  assign tick_o = en_i && (pc >= lim);

  always_ff @(posedge clk) begin
    if (rst || !en_i) pc <= '0;
    else if (tick_o)  pc <= '0;
    else              pc <= pc + 1'b1;
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import cap_timer16_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  tmr_ctrl_t         ctrl,
  input  logic              tick,
  input  logic              strobe_fall,
  input  logic              dir_lvl,
  input  logic              wr_cnt_lo,
  input  logic              wr_cnt_hi,
  input  logic              wr_rld_lo,
  input  logic              wr_rld_hi,
  input  logic              wr_flag,
  input  logic [HALF_W-1:0] wdata,
  output logic [2*HALF_W-1:0] cnt_o,
  output logic [2*HALF_W-1:0] rld_o,
  output logic              ovf_flag_o,
  output logic              ext_flag_o,
  output logic              irq_o,
  output logic              clk_out_o
);
  localparam int CW = 2 * HALF_W;

  logic [HALF_W-1:0] lo_q, hi_q, rlo_q, rhi_q;
  logic [CW-1:0]     cnt_hw, rld_hw, inc_v, dec_v;
  logic              dcen_act, count_up, at_max, at_rld;
  logic              ovf_evt, udf_evt, cap_evt, xrl_evt, xflag_set;
  logic              ovf_nxt, ext_nxt;

  assign cnt_o = {hi_q, lo_q};
  assign rld_o = {rhi_q, rlo_q};

  assign dcen_act  = ctrl.updn_en && !ctrl.cap_mode && !ctrl.sqw_mode;
  assign count_up  = !dcen_act || dir_lvl;
  assign at_max    = &cnt_o;
  assign at_rld    = (cnt_o == rld_o);
  assign ovf_evt   = tick && count_up && at_max;
  assign udf_evt   = tick && !count_up && at_rld;
  assign cap_evt   = ctrl.ext_en && strobe_fall && ctrl.cap_mode && !ctrl.sqw_mode;
  assign xrl_evt   = ctrl.ext_en && strobe_fall && !ctrl.cap_mode && !ctrl.sqw_mode && !dcen_act;
  assign xflag_set = ctrl.ext_en && strobe_fall && !dcen_act;

  // cascaded halves: high half moves on the low half's carry / borrow
  assign inc_v = {hi_q + HALF_W'(&lo_q), lo_q + 1'b1};
  assign dec_v = {hi_q - HALF_W'(lo_q == '0), lo_q - 1'b1};

  always_comb begin
    cnt_hw = cnt_o;
    if (xrl_evt)      cnt_hw = rld_o;
    else if (ovf_evt) cnt_hw = (ctrl.cap_mode && !ctrl.sqw_mode) ? '0 : rld_o;
    else if (udf_evt) cnt_hw = '1;
    else if (tick)    cnt_hw = count_up ? inc_v : dec_v;
  end

  assign rld_hw = cap_evt ? cnt_o : rld_o;

  always_comb begin
    ovf_nxt = ovf_flag_o | ((ovf_evt | udf_evt) & ~ctrl.sqw_mode);
    ext_nxt = dcen_act ? (ext_flag_o ^ (ovf_evt | udf_evt)) : (ext_flag_o | xflag_set);
    if (wr_flag) begin
      ovf_nxt = wdata[0];
      ext_nxt = wdata[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0; hi_q <= '0; rlo_q <= '0; rhi_q <= '0;
      ovf_flag_o <= 1'b0; ext_flag_o <= 1'b0; irq_o <= 1'b0; clk_out_o <= 1'b0;
    end else begin
      lo_q  <= wr_cnt_lo ? wdata : cnt_hw[HALF_W-1:0];
      hi_q  <= wr_cnt_hi ? wdata : cnt_hw[CW-1:HALF_W];
      rlo_q <= wr_rld_lo ? wdata : rld_hw[HALF_W-1:0];
      rhi_q <= wr_rld_hi ? wdata : rld_hw[CW-1:HALF_W];
      ovf_flag_o <= ovf_nxt;
      ext_flag_o <= ext_nxt;
      irq_o      <= ovf_nxt | ext_nxt;
      clk_out_o  <= clk_out_o ^ (ovf_evt & ctrl.sqw_mode & ctrl.out_en);
    end
  end

  // R5
  ovf_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt && !ctrl.cap_mode && !xrl_evt && !wr_cnt_lo && !wr_cnt_hi && !wr_rld_lo && !wr_rld_hi)
      |=> cnt_o == $past(rld_o));
  // R6
  udf_allones_chk: assert property (@(posedge clk) disable iff (rst)
    (udf_evt && !wr_cnt_lo && !wr_cnt_hi) |=> &cnt_o);
  // R4
  capture_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_evt && !wr_rld_lo && !wr_rld_hi) |=> rld_o == $past(cnt_o));
  // R9
  flag_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_flag |=> {ext_flag_o, ovf_flag_o} == $past(wdata[1:0]));
  // R7
  sqw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(ctrl.sqw_mode && ctrl.out_en) |=> $stable(clk_out_o));
  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !xrl_evt && !wr_cnt_lo && !wr_cnt_hi) |=> $stable(cnt_o));
endmodule

// File: rtl/cap_timer16.sv
module cap_timer16
  import cap_timer16_pkg::*;
#(
  parameter int HALF_W      = 8,
  parameter int DIV_SLOW    = 12,
  parameter int DIV_FAST    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [HALF_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [HALF_W-1:0] rd_data,
  input  logic              cnt_pin,
  input  logic              strobe_pin,
  output logic              ovf_flag,
  output logic              ext_flag,
  output logic              irq,
  output logic              clk_out
);
  localparam int CW = 2 * HALF_W;

  tmr_ctrl_t     ctrl_q;
  logic [1:0]    pin_lvl, pin_fall;
  logic          pre_tick, tick;
  logic [CW-1:0] cnt, rld;

  always_ff @(posedge clk) begin
    if (rst)                                ctrl_q <= '0;
    else if (wr_en && wr_addr == RA_CTRL)   ctrl_q <= tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  tmr_pin_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .pin_i({strobe_pin, cnt_pin}),
    .level_o(pin_lvl), .fall_o(pin_fall)
  );

  tmr_prescale #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_pre (
    .clk(clk), .rst(rst),
    .en_i(ctrl_q.run && (ctrl_q.sqw_mode || !ctrl_q.src_ext)),
    .fast_i(ctrl_q.sqw_mode),
    .tick_o(pre_tick)
  );

  assign tick = ctrl_q.run &&
                ((ctrl_q.sqw_mode || !ctrl_q.src_ext) ? pre_tick : pin_fall[0]);

  tmr_count_core #(.HALF_W(HALF_W)) u_core (
    .clk(clk), .rst(rst), .ctrl(ctrl_q), .tick(tick),
    .strobe_fall(pin_fall[1]), .dir_lvl(pin_lvl[1]),
    .wr_cnt_lo(wr_en && wr_addr == RA_CNTL),
    .wr_cnt_hi(wr_en && wr_addr == RA_CNTH),
    .wr_rld_lo(wr_en && wr_addr == RA_RLDL),
    .wr_rld_hi(wr_en && wr_addr == RA_RLDH),
    .wr_flag(wr_en && wr_addr == RA_FLAG),
    .wdata(wr_data),
    .cnt_o(cnt), .rld_o(rld),
    .ovf_flag_o(ovf_flag), .ext_flag_o(ext_flag),
    .irq_o(irq), .clk_out_o(clk_out)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        RA_CTRL: rd_data <= HALF_W'(ctrl_q);
        RA_FLAG: rd_data <= HALF_W'({ext_flag, ovf_flag});
        RA_CNTL: rd_data <= cnt[HALF_W-1:0];
        RA_CNTH: rd_data <= cnt[CW-1:HALF_W];
        RA_RLDL: rd_data <= rld[HALF_W-1:0];
        RA_RLDH: rd_data <= rld[CW-1:HALF_W];
        default: rd_data <= '0;
      endcase
    end
  end

  // R8
  irq_merge_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (ovf_flag | ext_flag));
endmodule

// File: tb/cap_timer16_bench.sv
module cap_timer16_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       cnt_pin = 1'b0;
  logic       strobe_pin = 1'b0;
  logic       ovf_flag, ext_flag, irq, clk_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cap_timer16 u_cap_timer16 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cnt_pin(cnt_pin), .strobe_pin(strobe_pin),
    .ovf_flag(ovf_flag), .ext_flag(ext_flag), .irq(irq), .clk_out(clk_out)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a + 3'd1, hi);
    d = {hi, lo};
  endtask

  task automatic wr16(input logic [2:0] a, input logic [15:0] d);
    wr(a, d[7:0]); wr(a + 3'd1, d[15:8]);
  endtask

  task automatic pulse_cnt();
    @(negedge clk); cnt_pin = 1'b1;
    repeat (3) @(negedge clk);
    cnt_pin = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_strobe();
    @(negedge clk); strobe_pin = 1'b1;
    repeat (3) @(negedge clk);
    strobe_pin = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R1", $sformatf("reg %0d after reset", a), v, 0);
    end
    check("R1", "ovf/ext/irq/clk_out after reset", {ovf_flag, ext_flag, irq, clk_out}, 0);
  endtask

  task automatic t_map();
    logic [7:0] v;
    wr(3'd0, 8'hFE);  // all control bits but run; bit7 must read 0
    rd(3'd0, v);
    check("R10", "control readback", v, 8'h7E);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_internal_rate();
    int t0 = 0, t1 = 0, t2 = 0, n = 0, cyc = 0;
    logic [7:0] last;
    wr16(3'd2, 16'h0000);
    wr(3'd0, 8'h01);
    @(negedge clk); rd_addr = 3'd2;
    @(negedge clk); last = rd_data;
    while (n < 3 && cyc < 200) begin
      @(negedge clk); cyc++;
      if (rd_data != last) begin
        last = rd_data;
        if (n == 0) t0 = cyc; else if (n == 1) t1 = cyc; else t2 = cyc;
        n++;
      end
    end
    wr(3'd0, 8'h00);
    check("R2", "increments seen", n, 3);
    check("R2", "first tick spacing", t1 - t0, 12);
    check("R2", "second tick spacing", t2 - t1, 12);
  endtask

  task automatic t_ext_count();
    logic [15:0] c;
    wr16(3'd2, 16'h0000);
    wr(3'd0, 8'h03);
    repeat (3) pulse_cnt();
    rd16(3'd2, c);
    check("R3", "count after 3 pin edges", c, 3);
    wr(3'd0, 8'h02);  // run cleared
    pulse_cnt();
    rd16(3'd2, c);
    check("R3", "count held with run=0", c, 3);
  endtask

  task automatic t_capture();
    logic [15:0] c;
    wr(3'd1, 8'h00);
    wr16(3'd2, 16'h0000);
    wr(3'd0, 8'h0F);
    repeat (5) pulse_cnt();
    pulse_strobe();
    rd16(3'd4, c);
    check("R4", "captured value", c, 16'h0005);
    check("R4", "ext flag after capture", ext_flag, 1);
    check("R8", "irq follows ext flag", irq, 1);
    wr(3'd1, 8'h00);
    @(negedge clk);
    check("R8", "irq after flag clear", irq, 0);
    wr16(3'd2, 16'hFFFF);
    pulse_cnt();
    rd16(3'd2, c);
    check("R4", "capture-mode wrap", c, 16'h0000);
    check("R4", "ovf flag after wrap", ovf_flag, 1);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_reload();
    logic [15:0] c;
    wr16(3'd4, 16'h1234);
    wr16(3'd2, 16'hFFFF);
    wr(3'd0, 8'h03);
    pulse_cnt();
    rd16(3'd2, c);
    check("R5", "reload on overflow", c, 16'h1234);
    check("R5", "ovf/ext after overflow", {ext_flag, ovf_flag}, 2'b01);
    wr(3'd1, 8'h00);
    wr16(3'd2, 16'h0050);
    wr(3'd0, 8'h0B);
    pulse_strobe();
    rd16(3'd2, c);
    check("R5", "reload on strobe edge", c, 16'h1234);
    check("R5", "ext flag on strobe", ext_flag, 1);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_updown();
    logic [15:0] c;
    wr16(3'd4, 16'h0010);
    wr16(3'd2, 16'h0012);
    wr(3'd0, 8'h1B);  // run, src_ext, ext_en, up/down; strobe low = down
    pulse_cnt();
    rd16(3'd2, c);
    check("R6", "down count", c, 16'h0011);
    pulse_cnt(); pulse_cnt();
    rd16(3'd2, c);
    check("R6", "underflow loads all ones", c, 16'hFFFF);
    check("R6", "flags after underflow", {ext_flag, ovf_flag}, 2'b11);
    @(negedge clk); strobe_pin = 1'b1;
    repeat (4) @(negedge clk);
    pulse_cnt();
    rd16(3'd2, c);
    check("R6", "up overflow reloads", c, 16'h0010);
    check("R6", "ext flag toggled back", ext_flag, 0);
    @(negedge clk); strobe_pin = 1'b0;
    repeat (4) @(negedge clk);
    check("R6", "strobe edge ignored for ext flag", ext_flag, 0);
    rd16(3'd2, c);
    check("R6", "strobe edge leaves count", c, 16'h0010);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_sqw();
    int t[3];
    int n = 0, cyc = 0;
    logic last;
    wr16(3'd4, 16'hFFFE);
    wr16(3'd2, 16'hFFFE);
    wr(3'd0, 8'h61);
    @(negedge clk); last = clk_out;
    while (n < 3 && cyc < 100) begin
      @(negedge clk); cyc++;
      if (clk_out != last) begin
        last = clk_out;
        t[n] = cyc;
        n++;
      end
    end
    check("R7", "toggles seen", n, 3);
    check("R7", "toggle spacing", t[1] - t[0], 4);
    check("R7", "toggle spacing 2", t[2] - t[1], 4);
    check("R7", "ovf flag untouched", ovf_flag, 0);
    wr(3'd0, 8'h21);
    @(negedge clk); last = clk_out;
    repeat (20) @(negedge clk);
    check("R7", "pin held with out_en=0", clk_out, last);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_priority();
    logic [15:0] c;
    // flag write against an overflow at the same edge
    wr(3'd1, 8'h00);
    wr16(3'd2, 16'hFFFF);
    wr(3'd0, 8'h07);
    @(negedge clk); cnt_pin = 1'b1;
    repeat (3) @(negedge clk);
    cnt_pin = 1'b0;
    @(posedge clk); @(posedge clk);
    wr(3'd1, 8'h00);
    rd16(3'd2, c);
    check("R9", "overflow did happen", c, 16'h0000);
    check("R9", "flag write beats hw set", ovf_flag, 0);
    // count write against a tick at the same edge
    wr16(3'd2, 16'h0005);
    wr(3'd0, 8'h03);
    @(negedge clk); cnt_pin = 1'b1;
    repeat (3) @(negedge clk);
    cnt_pin = 1'b0;
    @(posedge clk); @(posedge clk);
    wr(3'd2, 8'h40);
    rd16(3'd2, c);
    check("R9", "count write beats tick", c, 16'h0040);
    wr(3'd0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_map();
    t_internal_rate();
    t_ext_count();
    t_capture();
    t_reload();
    t_updown();
    t_sqw();
    t_priority();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual=hung expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule